// File: doc/BRIEF.md
# Reset and Interrupt Sequencer

This block decides, at each instruction boundary of a 16-bit CPU core with an 8-bit emulation mode, which pending event to service. The candidates are a non-maskable interrupt, a maskable interrupt, a soft reset and a power-on. Request pulses are held in pending flags until a boundary strobe arrives while the sequencer is idle. The sequencer then takes the highest-priority event, clears its flag and latches the vector address. It fixes the mode and the starting stack pointer for the entry.

After an optional settling wait, the sequencer runs the entry on a single-cycle byte bus. Interrupts and soft reset push a three-byte frame and then fetch the two vector bytes. Power-on only fetches the vector. A one-cycle `done` then presents the new program counter, the final stack pointer and the mode to the core.

A soft reset differs from a power-on. It keeps the low byte of the running stack pointer, forces the high byte to 0x01, and pushes a frame that wraps inside page 1. A power-on starts from 0x01FF and pushes nothing.

Top module: `rst_irq_seq`

## Requirements
- R1: When several events are pending at a boundary, they are taken in the order non-maskable, maskable, soft reset, power-on. One event is taken per boundary.
- R2: The non-maskable vector is 0xFFEA when `emu_in`=0 and 0xFFFA when `emu_in`=1.
- R3: The maskable vector is 0xFFEE when `emu_in`=0 and 0xFFFE when `emu_in`=1.
- R4: Power-on selects a stack of 0x01FF and emulation mode. It stays idle on the bus for PWR_WAIT cycles (default 186), then reads 0xFFFC and then 0xFFFD, and never writes. `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}.
- R5: Soft reset forces emulation mode and a stack of {0x01, `sp_in`[7:0]}. It stays idle on the bus for RST_WAIT cycles (default 132), then pushes a frame and fetches through vector 0xFFFC.
- R6: A frame is three writes: `pc_in`[15:8], then `pc_in`[7:0], then `flags_in`. Each write goes to the current stack pointer, and the stack pointer is decremented after each write. Interrupts start the frame in the cycle after selection.
- R7: In emulation mode only the stack low byte decrements, so the high byte is kept. For example, 0x0101 writes 0x0101, 0x0100, 0x01FF and ends at 0x01FE.
- R8: In native mode the stack decrements as a full 16-bit value. For example, 0x0100 writes 0x0100, 0x00FF, 0x00FE and ends at 0x00FD.
- R9: A soft-reset request that arrives while power-on is pending, or in the same cycle as the power-on request, leaves no soft reset pending.
- R10: `pend_any` is high while any event is pending. Taking an event clears its flag at selection, so each request is serviced once.
- R11: `busy` is high from the cycle after selection through the `done` cycle. `done` is a one-cycle pulse after the second vector byte, with `pc_out`, `sp_out`, `emu_out` and `vec_addr` valid.
- R12: After reset, `busy`, `done`, `bus_rd`, `bus_wr` and `pend_any` are low.
- R13: Without a boundary strobe no event is taken, and a strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_req | input | 1 | Maskable interrupt request pulse |
| srst_req | input | 1 | Soft reset request pulse |
| pwr_req | input | 1 | Power-on request pulse |
| boundary | input | 1 | Instruction boundary strobe |
| emu_in | input | 1 | Current mode, 1 = emulation |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter to push |
| flags_in | input | 8 | Status flags to push |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_rd` is high |
| bus_rd | output | 1 | Vector byte read strobe |
| bus_wr | output | 1 | Stack write strobe |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| vec_addr | output | 16 | Vector of the event being serviced |
| pc_out | output | 16 | Program counter fetched from the vector |
| sp_out | output | 16 | Working stack pointer |
| emu_out | output | 1 | Mode for the serviced event |
| pend_any | output | 1 | Any event pending |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion and load strobe |

## Verification
Some properties are checked on every cycle by the assertions. These cover the page-1 stack high byte during emulation-mode pushes and the exact 16-bit decrement in native mode. They also cover the blocking of soft reset by a pending power-on, the clearing of a flag that has been taken, the absence of writes during power-on, the single-cycle `done` and the exclusive bus strobes. Other behaviour shows only in bench scenarios: the order in which stacked events drain, the vector chosen in each mode, the wait lengths, and the exact address and data of every bus cycle. The scenarios also show the final stack values for the wrapping cases 0x0100, 0x0101 and 0x0102.

// File: rtl/rst_irq_pkg.sv
package rst_irq_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [AW-1:0] SP_POWER   = 16'h01FF;

    typedef enum logic [2:0] {
        EV_NONE, EV_NMI, EV_IRQ, EV_SRST, EV_PWR
    } evt_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_PUSH, ST_RDLO, ST_RDHI, ST_DONE
    } st_e;

    typedef struct packed {
        logic nmi;
        logic irq;
        logic srst;
        logic pwr;
    } pend_t;

    function automatic evt_e pick(pend_t p);
        if (p.nmi)       return EV_NMI;
        else if (p.irq)  return EV_IRQ;
        else if (p.srst) return EV_SRST;
        else if (p.pwr)  return EV_PWR;
        else             return EV_NONE;
    endfunction

    function automatic logic [AW-1:0] vec_of(evt_e e, logic emu);
        case (e)
            EV_NMI:  return emu ? 16'hFFFA : 16'hFFEA;
            EV_IRQ:  return emu ? 16'hFFFE : 16'hFFEE;
            default: return 16'hFFFC;
        endcase
    endfunction

    function automatic logic [AW-1:0] sp_step(logic [AW-1:0] sp, logic emu);
        if (emu) return {sp[AW-1:DW], sp[DW-1:0] - 8'd1};
        else     return sp - 16'd1;
    endfunction

endpackage

// File: rtl/rst_irq_pend.sv
module rst_irq_pend
    import rst_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  nmi_req,
    input  logic  irq_req,
    input  logic  srst_req,
    input  logic  pwr_req,
    input  evt_e  clr,
    output pend_t pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend.nmi <= nmi_req | (pend.nmi & (clr != EV_NMI));
            pend.irq <= irq_req | (pend.irq & (clr != EV_IRQ));
            pend.pwr <= pwr_req | (pend.pwr & (clr != EV_PWR));
            if (srst_req)
                pend.srst <= ~(pend.pwr | pwr_req);
            else
                pend.srst <= pend.srst & (clr != EV_SRST);
        end
    end

    AST_SRST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        srst_req && (pend.pwr || pwr_req) |=> !pend.srst); // R9

    AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr == EV_NMI) && !nmi_req |=> !pend.nmi); // R10

endmodule

// File: rtl/rst_irq_stack.sv
module rst_irq_stack
    import rst_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          dec,
    input  logic          emu,
    output logic [AW-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst)       sp <= SP_POWER;
        else if (load) sp <= load_val;
        else if (dec)  sp <= sp_step(sp, emu);
    end

    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        dec && emu && !load |=> sp[AW-1:DW] == $past(sp[AW-1:DW])); // R7

    AST_NATIVE_DEC: assert property (@(posedge clk) disable iff (rst)
        dec && !emu && !load |=> sp == $past(sp) - 16'd1); // R8

endmodule

// File: rtl/rst_irq_fsm.sv
module rst_irq_fsm
    import rst_irq_pkg::*;
#(
    parameter int PWR_WAIT = 186,
    parameter int RST_WAIT = 132
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  pend_t         pend,
    input  logic          emu_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] bus_rdata,
    input  logic [AW-1:0] sp,
    output evt_e          clr,
    output logic          sp_load,
    output logic [AW-1:0] sp_load_val,
    output logic          sp_dec,
    output logic          emu_work,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [AW-1:0] vec_addr,
    output logic [AW-1:0] pc_out,
    output logic          busy,
    output logic          done
);

    localparam int WMAX = (PWR_WAIT > RST_WAIT) ? PWR_WAIT : RST_WAIT;
    localparam int CW   = (WMAX < 2) ? 1 : $clog2(WMAX + 1);
    localparam logic [CW-1:0] PWR_W = CW'(PWR_WAIT);
    localparam logic [CW-1:0] RST_W = CW'(RST_WAIT);

    st_e           st;
    evt_e          kind;
    evt_e          sel;
    logic          take;
    logic          emu_sel;
    logic [CW-1:0] wait_sel;
    logic [CW-1:0] cnt;
    logic [1:0]    idx;
    logic [AW-1:0] pc_snap;
    logic [DW-1:0] fl_snap;
    logic [DW-1:0] lo_r;

    always_comb begin
        sel     = pick(pend);
        take    = (st == ST_IDLE) && boundary && (sel != EV_NONE);
        clr     = take ? sel : EV_NONE;
        emu_sel = (sel == EV_SRST || sel == EV_PWR) ? 1'b1 : emu_in;
        case (sel)
            EV_PWR:  begin wait_sel = PWR_W; sp_load_val = SP_POWER; end
            EV_SRST: begin wait_sel = RST_W; sp_load_val = {STACK_PAGE, sp_in[DW-1:0]}; end
            default: begin wait_sel = '0;    sp_load_val = sp_in; end
        endcase
        sp_load = take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; kind <= EV_NONE; vec_addr <= '0; emu_work <= 1'b1;
            cnt <= '0; idx <= '0; pc_snap <= '0; fl_snap <= '0;
            lo_r <= '0; pc_out <= '0;
        end else begin
            case (st)
                ST_IDLE: if (take) begin
                    kind     <= sel;
                    vec_addr <= vec_of(sel, emu_sel);
                    emu_work <= emu_sel;
                    pc_snap  <= pc_in;
                    fl_snap  <= flags_in;
                    idx      <= '0;
                    if (wait_sel != '0) begin
                        cnt <= wait_sel - 1'b1;
                        st  <= ST_WAIT;
                    end else begin
                        st  <= (sel == EV_PWR) ? ST_RDLO : ST_PUSH;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) st <= (kind == EV_PWR) ? ST_RDLO : ST_PUSH;
                    else           cnt <= cnt - 1'b1;
                end
                ST_PUSH: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd2) st <= ST_RDLO;
                end
                ST_RDLO: begin lo_r <= bus_rdata; st <= ST_RDHI; end
                ST_RDHI: begin pc_out <= {bus_rdata, lo_r}; st <= ST_DONE; end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sp_dec = (st == ST_PUSH);
        bus_wr = (st == ST_PUSH);
        bus_rd = (st == ST_RDLO) || (st == ST_RDHI);
        busy   = (st != ST_IDLE);
        done   = (st == ST_DONE);
        case (st)
            ST_PUSH: bus_addr = sp;
            ST_RDLO: bus_addr = vec_addr;
            ST_RDHI: bus_addr = vec_addr + 16'd1;
            default: bus_addr = '0;
        endcase
        case (idx)
            2'd0:    bus_wdata = pc_snap[AW-1:DW];
            2'd1:    bus_wdata = pc_snap[DW-1:0];
            default: bus_wdata = fl_snap;
        endcase
    end

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_rd)); // R11

    AST_POWER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> kind != EV_PWR); // R4

    AST_NO_STROBE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !busy && !boundary |=> !busy); // R13

endmodule

// File: rtl/rst_irq_seq.sv
module rst_irq_seq
    import rst_irq_pkg::*;
#(
    parameter int PWR_WAIT = 186,
    parameter int RST_WAIT = 132
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi_req,
    input  logic        irq_req,
    input  logic        srst_req,
    input  logic        pwr_req,
    input  logic        boundary,
    input  logic        emu_in,
    input  logic [15:0] sp_in,
    input  logic [15:0] pc_in,
    input  logic [7:0]  flags_in,
    input  logic [7:0]  bus_rdata,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic [15:0] vec_addr,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic        emu_out,
    output logic        pend_any,
    output logic        busy,
    output logic        done
);

    pend_t         pend;
    evt_e          clr;
    logic          sp_load;
    logic [AW-1:0] sp_load_val;
    logic          sp_dec;

    rst_irq_pend u_pend (
        .clk      (clk),
        .rst      (rst),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .srst_req (srst_req),
        .pwr_req  (pwr_req),
        .clr      (clr),
        .pend     (pend)
    );

    rst_irq_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .load     (sp_load),
        .load_val (sp_load_val),
        .dec      (sp_dec),
        .emu      (emu_out),
        .sp       (sp_out)
    );

    rst_irq_fsm #(
        .PWR_WAIT (PWR_WAIT),
        .RST_WAIT (RST_WAIT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .boundary    (boundary),
        .pend        (pend),
        .emu_in      (emu_in),
        .sp_in       (sp_in),
        .pc_in       (pc_in),
        .flags_in    (flags_in),
        .bus_rdata   (bus_rdata),
        .sp          (sp_out),
        .clr         (clr),
        .sp_load     (sp_load),
        .sp_load_val (sp_load_val),
        .sp_dec      (sp_dec),
        .emu_work    (emu_out),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .vec_addr    (vec_addr),
        .pc_out      (pc_out),
        .busy        (busy),
        .done        (done)
    );

    assign pend_any = |{pend.nmi, pend.irq, pend.srst, pend.pwr};

endmodule

// File: tb/rst_irq_seq_bench.sv
module rst_irq_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PWR_WAIT   = 186;
    localparam int RST_WAIT   = 132;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 0, irq_req = 0, srst_req = 0, pwr_req = 0;
    logic        boundary = 0, emu_in = 0;
    logic [15:0] sp_in = 16'h0, pc_in = 16'h0;
    logic [7:0]  flags_in = 8'h0;
    logic [7:0]  bus_rdata;
    logic        bus_rd, bus_wr, emu_out, pend_any, busy, done;
    logic [15:0] bus_addr, vec_addr, pc_out, sp_out;
    logic [7:0]  bus_wdata;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } bus_item_t;

    bus_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return 8'(a[7:0] * 3 + 8'h11) ^ a[15:8];
    endfunction

    assign bus_rdata = mem_byte(bus_addr);

    rst_irq_seq #(.PWR_WAIT(PWR_WAIT), .RST_WAIT(RST_WAIT)) u_rst_irq_seq (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .srst_req(srst_req), .pwr_req(pwr_req), .boundary(boundary),
        .emu_in(emu_in), .sp_in(sp_in), .pc_in(pc_in), .flags_in(flags_in),
        .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .vec_addr(vec_addr),
        .pc_out(pc_out), .sp_out(sp_out), .emu_out(emu_out),
        .pend_any(pend_any), .busy(busy), .done(done)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares every bus cycle against the expected queue
    always @(negedge clk) begin
        if (!rst && (bus_rd || bus_wr)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected bus cycle addr", {16'h0, bus_addr}, 32'h0);
            end else begin
                bus_item_t it;
                it = exp_q.pop_front();
                check(bus_wr == it.wr, it.tag, "bus direction (1=write)", {31'h0, bus_wr}, {31'h0, it.wr});
                check(bus_addr == it.addr, it.tag, "bus address", {16'h0, bus_addr}, {16'h0, it.addr});
                if (it.wr)
                    check(bus_wdata == it.data, it.tag, "push data", {24'h0, bus_wdata}, {24'h0, it.data});
            end
        end
    end

    task automatic raise(input logic n, input logic i, input logic s, input logic p);
        nmi_req = n; irq_req = i; srst_req = s; pwr_req = p;
        @(negedge clk);
        nmi_req = 0; irq_req = 0; srst_req = 0; pwr_req = 0;
    endtask

    // driver: queues the expected bus cycles, strobes the boundary, checks completion
    task automatic service(input string tag, input logic [15:0] vec, input logic [15:0] sp0,
                           input logic emu, input int npush, input int wait_n,
                           input logic [15:0] pc, input logic [7:0] fl, input logic emu_exp);
        logic [15:0] s;
        int first;
        int k;
        logic seen;
        s = sp0;
        for (int i = 0; i < npush; i++) begin
            bus_item_t w;
            w.wr = 1'b1; w.addr = s; w.tag = tag;
            w.data = (i == 0) ? pc[15:8] : (i == 1) ? pc[7:0] : fl;
            exp_q.push_back(w);
            s = emu ? {s[15:8], s[7:0] - 8'd1} : s - 16'd1;
        end
        begin
            bus_item_t r0, r1;
            r0.wr = 1'b0; r0.addr = vec;         r0.data = 8'h0; r0.tag = tag;
            r1.wr = 1'b0; r1.addr = vec + 16'd1; r1.data = 8'h0; r1.tag = tag;
            exp_q.push_back(r0);
            exp_q.push_back(r1);
        end
        pc_in = pc; flags_in = fl;
        boundary = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R11", "busy after selection", {31'h0, busy}, 32'h1);
        first = -1; seen = 1'b0;
        for (k = 1; k < 600; k++) begin
            if ((bus_rd || bus_wr) && first < 0) first = k;
            if (done) begin seen = 1'b1; break; end
            boundary = (k % 7 == 0); // R13: strobes while busy must be ignored
            @(negedge clk);
        end
        boundary = 1'b0;
        check(seen, "R11", "done reached", {31'h0, seen}, 32'h1);
        check(first == wait_n + 1, tag, "cycles to first bus op", first, wait_n + 1);
        check(pc_out == {mem_byte(vec + 16'd1), mem_byte(vec)}, tag, "pc_out",
              {16'h0, pc_out}, {16'h0, mem_byte(vec + 16'd1), mem_byte(vec)});
        check(sp_out == s, tag, "final stack", {16'h0, sp_out}, {16'h0, s});
        check(emu_out == emu_exp, tag, "emu_out", {31'h0, emu_out}, {31'h0, emu_exp});
        check(vec_addr == vec, tag, "vec_addr", {16'h0, vec_addr}, {16'h0, vec});
        check(exp_q.size() == 0, tag, "bus cycles outstanding", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(!done && !busy, "R11", "done one cycle then idle", {30'h0, done, busy}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(!busy && !done, "R12", "busy/done after reset", {30'h0, busy, done}, 0);
        check(!bus_rd && !bus_wr, "R12", "bus strobes after reset", {30'h0, bus_rd, bus_wr}, 0);
        check(!pend_any, "R12", "pending after reset", {31'h0, pend_any}, 0);

        // R4 power-on, R9 soft reset blocked while power pending
        raise(0, 0, 0, 1);
        raise(0, 0, 1, 0);
        check(pend_any, "R10", "pending after power request", {31'h0, pend_any}, 1);
        emu_in = 0; sp_in = 16'h1234;
        service("R4", 16'hFFFC, 16'h01FF, 1'b1, 0, PWR_WAIT, 16'hBEEF, 8'h33, 1'b1);
        check(!pend_any, "R9", "no soft reset left pending", {31'h0, pend_any}, 0);
        boundary = 1'b1; @(negedge clk); boundary = 1'b0; @(negedge clk);
        check(!busy, "R9", "no sequence after blocked soft reset", {31'h0, busy}, 0);

        // R9 same-cycle request
        raise(0, 0, 1, 1);
        service("R9 R4", 16'hFFFC, 16'h01FF, 1'b1, 0, PWR_WAIT, 16'h0102, 8'h00, 1'b1);
        check(!pend_any, "R9", "same-cycle soft reset dropped", {31'h0, pend_any}, 0);

        // R2 R8 non-maskable, native
        emu_in = 0; sp_in = 16'h0100;
        raise(1, 0, 0, 0);
        service("R2 R6 R8", 16'hFFEA, 16'h0100, 1'b0, 3, 0, 16'hA1B2, 8'h5C, 1'b0);
        // R2 R7 non-maskable, emulation
        emu_in = 1; sp_in = 16'h0101;
        raise(1, 0, 0, 0);
        service("R2 R7", 16'hFFFA, 16'h0101, 1'b1, 3, 0, 16'h3456, 8'h81, 1'b1);

        // R3 maskable, both modes
        emu_in = 0; sp_in = 16'h2000;
        raise(0, 1, 0, 0);
        service("R3 R8", 16'hFFEE, 16'h2000, 1'b0, 3, 0, 16'h7788, 8'h02, 1'b0);
        emu_in = 1; sp_in = 16'h01FF;
        raise(0, 1, 0, 0);
        service("R3", 16'hFFFE, 16'h01FF, 1'b1, 3, 0, 16'h99AA, 8'h34, 1'b1);

        // R5 soft reset from native mode with foreign high byte
        emu_in = 0; sp_in = 16'h1F02;
        raise(0, 0, 1, 0);
        service("R5 R7", 16'hFFFC, 16'h0102, 1'b1, 3, RST_WAIT, 16'hCAFE, 8'h0F, 1'b1);
        emu_in = 1; sp_in = 16'h0100;
        raise(0, 0, 1, 0);
        service("R5 R7", 16'hFFFC, 16'h0100, 1'b1, 3, RST_WAIT, 16'h1357, 8'hF0, 1'b1);

        // R1 priority with three pending, R13 no take without strobe
        emu_in = 0; sp_in = 16'h0300;
        raise(1, 1, 1, 0);
        repeat (3) @(negedge clk);
        check(!busy, "R13", "no take without boundary", {31'h0, busy}, 0);
        service("R1 R2", 16'hFFEA, 16'h0300, 1'b0, 3, 0, 16'h1111, 8'h11, 1'b0);
        check(pend_any, "R10", "others still pending", {31'h0, pend_any}, 1);
        service("R1 R3", 16'hFFEE, 16'h0300, 1'b0, 3, 0, 16'h2222, 8'h22, 1'b0);
        service("R1 R5", 16'hFFFC, 16'h0100, 1'b1, 3, RST_WAIT, 16'h3333, 8'h33, 1'b1);
        check(!pend_any, "R10", "all serviced once", {31'h0, pend_any}, 0);

        // R1 maskable ahead of power-on
        emu_in = 0; sp_in = 16'h0480;
        raise(0, 1, 0, 1);
        service("R1 R3", 16'hFFEE, 16'h0480, 1'b0, 3, 0, 16'h4444, 8'h44, 1'b0);
        service("R1 R4", 16'hFFFC, 16'h01FF, 1'b1, 0, PWR_WAIT, 16'h5555, 8'h55, 1'b1);
        check(!pend_any, "R10", "queue drained", {31'h0, pend_any}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule